// File: doc/BRIEF.md
# Level-0 Data Buffer with Prefetch Filter

This block is a very small direct-mapped data store that sits in front of the first-level data cache. Every processor load and store reaches it before any other part of the memory path. A load that finds its word here is answered in the same cycle. A load that misses goes to the L1 port, and the returned word is installed when it arrives. Stores are passed through to L1 and update a resident copy. A store that misses leaves the buffer unchanged.

A second request source, the prefetch input, carries addresses from an offset-prediction table. A prefetch is first filtered by a tag lookup alone. If the tag matches, the prefetch is dropped and the data array is not read. If it misses, the word is fetched from L1 and installed, and the processor sees nothing. The L1 side allows one transaction in flight. A processor request always takes precedence over a prefetch. A load to the word that an in-flight prefetch is fetching waits for that fill and does not issue a second L1 request.

Top module: `l0_prefetch_buffer`

## Requirements
- R1: After reset no line is valid. No L1 request is made until a request arrives, and the first load of any address misses.
- R2: A load whose line is resident raises cpu_done with the stored word in the cycle it is presented, and no L1 request follows.
- R3: A load miss issues one L1 read for the same address in the next cycle. cpu_done comes with the returned word L1_LAT+1 cycles after the load was first presented, where L1_LAT is the L1 response delay counted from the cycle of l1_req. The word is then resident.
- R4: The line index is the address modulo DEPTH and the tag is the rest of the address. A load to another tag at the same index replaces the resident line, so the earlier address misses again.
- R5: Every store issues one L1 write with l1_we high, carrying its address and data, and completes on the L1 response after L1_LAT+1 cycles. A store to a resident line also updates the buffered copy, so a later load hits with the new data.
- R6: A store that misses does not allocate. The stored address still misses afterwards, and the line already at that index stays resident.
- R7: A prefetch that misses, presented while the buffer is idle and no processor request is present, issues one L1 read and installs the word without raising cpu_done. A later load of that address hits.
- R8: A prefetch whose tag matches a resident line is dropped, and no L1 request is made.
- R9: A prefetch presented while an L1 transaction is outstanding is dropped. It makes no L1 request and installs nothing.
- R10: When a processor request and a prefetch arrive in the same idle cycle, the processor request is served and the prefetch is dropped.
- R11: A load to the address of an in-flight prefetch completes with the fill data in the response cycle, without a second L1 request. A load to any other address waits until the buffer is idle and is then handled as a hit or a miss.
- R12: At most one L1 transaction is outstanding, and l1_req is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| pf_valid | input | 1 | Prefetch address present (one cycle) |
| pf_addr | input | ADDR_W | Prefetch word address |
| l1_req | output | 1 | L1 transaction start pulse |
| l1_we | output | 1 | L1 transaction is a write |
| l1_addr | output | ADDR_W | L1 word address |
| l1_wdata | output | DATA_W | L1 write data |
| l1_resp_valid | input | 1 | L1 response / write acknowledge |
| l1_rdata | input | DATA_W | L1 read data, valid with l1_resp_valid |

## Verification
The checker assumes that the processor keeps cpu_req, cpu_we, cpu_addr and cpu_wdata steady from the cycle a request appears until the cycle cpu_done is seen. It also assumes that L1 answers only while a transaction is outstanding, and at least one cycle after l1_req. The bench drives its inputs only at falling edges and releases a request only after observing cpu_done. Its L1 model answers after a fixed delay of pipeline stages behind l1_req, so these conditions always hold. Prefetch pulses are placed in chosen cycles relative to outstanding misses, so that the busy, same-cycle and in-flight cases each occur deliberately.

// File: rtl/l0pb_pkg.sv
package l0pb_pkg;
   typedef enum logic [1:0] {
      SRC_NONE     = 2'd0,
      SRC_DEMAND_RD = 2'd1,
      SRC_DEMAND_WR = 2'd2,
      SRC_PREFETCH  = 2'd3
   } l1_src_e;
endpackage

// File: rtl/l0pb_tags.sv
module l0pb_tags #(
   parameter int DEPTH = 32,
   parameter int IDX_W = 5,
   parameter int TAG_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] dem_idx,
   input  logic [TAG_W-1:0] dem_tag,
   input  logic [IDX_W-1:0] pf_idx,
   input  logic [TAG_W-1:0] pf_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             dem_hit,
   output logic             pf_hit
);
   logic [DEPTH-1:0] vld;
   logic [TAG_W-1:0] tg [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            v_q <= 1'b1;
            t_q <= wr_tag;
         end
      end
      assign vld[e] = v_q;
      assign tg[e]  = t_q;
   end

   assign dem_hit = vld[dem_idx] && (tg[dem_idx] == dem_tag);
   assign pf_hit  = vld[pf_idx]  && (tg[pf_idx]  == pf_tag);
endmodule

// File: rtl/l0pb_data.sv
module l0pb_data #(
   parameter int DEPTH  = 32,
   parameter int IDX_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/l0pb_ctrl.sv
module l0pb_ctrl
   import l0pb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              dem_hit,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              pf_valid,
   input  logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_hit,
   input  logic              l1_resp_valid,
   input  logic [DATA_W-1:0] l1_rdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              l1_req,
   output logic              l1_we,
   output logic [ADDR_W-1:0] l1_addr,
   output logic [DATA_W-1:0] l1_wdata,
   output logic              tag_wr_en,
   output logic [ADDR_W-1:0] tag_wr_addr,
   output logic              data_wr_en,
   output logic [ADDR_W-1:0] data_wr_addr,
   output logic [DATA_W-1:0] data_wr_data
);
   logic              busy_q;
   logic              l1_req_q;
   l1_src_e           src_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_wdata_q;

   logic idle, resp, rd_hit, launch_dem, launch_pf, resp_done, fill, wr_hit_upd;

   always_comb begin
      idle       = !busy_q;
      resp       = busy_q && l1_resp_valid;
      rd_hit     = idle && cpu_req && !cpu_we && dem_hit;
      launch_dem = idle && cpu_req && !rd_hit;
      launch_pf  = idle && !cpu_req && pf_valid && !pf_hit;
      resp_done  = resp && cpu_req &&
                   ((src_q == SRC_DEMAND_WR) || (!cpu_we && cpu_addr == pend_addr_q));
      fill       = resp && (src_q != SRC_DEMAND_WR);
      wr_hit_upd = launch_dem && cpu_we && dem_hit;
   end

   assign cpu_done     = rd_hit || resp_done;
   assign cpu_rdata    = rd_hit ? rd_data : l1_rdata;
   assign tag_wr_en    = fill;
   assign tag_wr_addr  = pend_addr_q;
   assign data_wr_en   = fill || wr_hit_upd;
   assign data_wr_addr = fill ? pend_addr_q : cpu_addr;
   assign data_wr_data = fill ? l1_rdata : cpu_wdata;
   assign l1_req       = l1_req_q;
   assign l1_we        = l1_req_q && (src_q == SRC_DEMAND_WR);
   assign l1_addr      = pend_addr_q;
   assign l1_wdata     = pend_wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         l1_req_q     <= 1'b0;
         src_q        <= SRC_NONE;
         pend_addr_q  <= '0;
         pend_wdata_q <= '0;
      end else begin
         l1_req_q <= launch_dem || launch_pf;
         if (launch_dem || launch_pf) begin
            busy_q       <= 1'b1;
            pend_addr_q  <= launch_dem ? cpu_addr : pf_addr;
            pend_wdata_q <= cpu_wdata;
            src_q        <= !launch_dem ? SRC_PREFETCH :
                            (cpu_we ? SRC_DEMAND_WR : SRC_DEMAND_RD);
         end else if (resp) begin
            busy_q <= 1'b0;
            src_q  <= SRC_NONE;
         end
      end
   end
endmodule

// File: rtl/l0_prefetch_buffer.sv
module l0_prefetch_buffer #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              pf_valid,
   input  logic [ADDR_W-1:0] pf_addr,
   output logic              l1_req,
   output logic              l1_we,
   output logic [ADDR_W-1:0] l1_addr,
   output logic [DATA_W-1:0] l1_wdata,
   input  logic              l1_resp_valid,
   input  logic [DATA_W-1:0] l1_rdata
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic              dem_hit, pf_hit;
   logic [DATA_W-1:0] rd_data;
   logic              tag_wr_en, data_wr_en;
   logic [ADDR_W-1:0] tag_wr_addr, data_wr_addr;
   logic [DATA_W-1:0] data_wr_data;

   l0pb_tags #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .dem_idx (cpu_addr[IDX_W-1:0]),
      .dem_tag (cpu_addr[ADDR_W-1:IDX_W]),
      .pf_idx  (pf_addr[IDX_W-1:0]),
      .pf_tag  (pf_addr[ADDR_W-1:IDX_W]),
      .wr_en   (tag_wr_en),
      .wr_idx  (tag_wr_addr[IDX_W-1:0]),
      .wr_tag  (tag_wr_addr[ADDR_W-1:IDX_W]),
      .dem_hit (dem_hit),
      .pf_hit  (pf_hit)
   );

   l0pb_data #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_idx  (cpu_addr[IDX_W-1:0]),
      .rd_data (rd_data),
      .wr_en   (data_wr_en),
      .wr_idx  (data_wr_addr[IDX_W-1:0]),
      .wr_data (data_wr_data)
   );

   l0pb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .dem_hit       (dem_hit),
      .rd_data       (rd_data),
      .pf_valid      (pf_valid),
      .pf_addr       (pf_addr),
      .pf_hit        (pf_hit),
      .l1_resp_valid (l1_resp_valid),
      .l1_rdata      (l1_rdata),
      .cpu_done      (cpu_done),
      .cpu_rdata     (cpu_rdata),
      .l1_req        (l1_req),
      .l1_we         (l1_we),
      .l1_addr       (l1_addr),
      .l1_wdata      (l1_wdata),
      .tag_wr_en     (tag_wr_en),
      .tag_wr_addr   (tag_wr_addr),
      .data_wr_en    (data_wr_en),
      .data_wr_addr  (data_wr_addr),
      .data_wr_data  (data_wr_data)
   );
endmodule

// File: rtl/l0pb_chk.sv
module l0pb_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_done,
   input logic              l1_req,
   input logic              l1_we,
   input logic [ADDR_W-1:0] l1_addr,
   input logic [DATA_W-1:0] l1_wdata,
   input logic              l1_resp_valid
);
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             out_q <= 1'b0;
      else if (l1_req)        out_q <= 1'b1;
      else if (l1_resp_valid) out_q <= 1'b0;
   end

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req |=> !l1_req); // R12
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req |-> !out_q); // R12
   AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      l1_resp_valid |-> out_q); // R12
   AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_req); // R2
   AST_HIT_NO_L1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !l1_resp_valid) |=> !l1_req); // R2
   AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_we) |-> l1_resp_valid); // R5
   AST_STORE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_req && l1_we) |-> (cpu_req && cpu_we && l1_addr == cpu_addr && l1_wdata == cpu_wdata)); // R5
endmodule

bind l0_prefetch_buffer l0pb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req       (cpu_req),
   .cpu_we        (cpu_we),
   .cpu_addr      (cpu_addr),
   .cpu_wdata     (cpu_wdata),
   .cpu_done      (cpu_done),
   .l1_req        (l1_req),
   .l1_we         (l1_we),
   .l1_addr       (l1_addr),
   .l1_wdata      (l1_wdata),
   .l1_resp_valid (l1_resp_valid)
);

// File: tb/l0_prefetch_buffer_tb.sv
module l0_prefetch_buffer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 8;
   localparam int L1_LAT = 2;
   localparam int NADDR  = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic cpu_done;
   logic [DATA_W-1:0] cpu_rdata;
   logic pf_valid = 1'b0;
   logic [ADDR_W-1:0] pf_addr = '0;
   logic l1_req, l1_we;
   logic [ADDR_W-1:0] l1_addr;
   logic [DATA_W-1:0] l1_wdata;
   logic l1_resp_valid;
   logic [DATA_W-1:0] l1_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   l0_prefetch_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .pf_valid(pf_valid), .pf_addr(pf_addr),
      .l1_req(l1_req), .l1_we(l1_we), .l1_addr(l1_addr), .l1_wdata(l1_wdata),
      .l1_resp_valid(l1_resp_valid), .l1_rdata(l1_rdata)
   );

   // L1 model: fixed delay from l1_req to response
   logic [DATA_W-1:0] mem [NADDR];
   logic              vp [L1_LAT];
   logic [ADDR_W-1:0] ap [L1_LAT];
   int                l1_cnt;

   initial begin
      for (int i = 0; i < NADDR; i++) mem[i] = DATA_W'((i * 16'h0131) ^ 16'h5A00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < L1_LAT; k++) begin vp[k] <= 1'b0; ap[k] <= '0; end
         l1_cnt <= 0;
      end else begin
         vp[0] <= l1_req;
         ap[0] <= l1_addr;
         for (int k = 1; k < L1_LAT; k++) begin vp[k] <= vp[k-1]; ap[k] <= ap[k-1]; end
         if (l1_req) l1_cnt <= l1_cnt + 1;
         if (l1_req && l1_we) mem[l1_addr] <= l1_wdata;
      end
   end
   assign l1_resp_valid = vp[L1_LAT-1];
   assign l1_rdata      = mem[ap[L1_LAT-1]];

   // reference contents
   bit ref_v [DEPTH];
   int ref_t [DEPTH];
   int n_chk = 0, n_err = 0;

   function automatic bit ref_hit(int a);
      return ref_v[a % DEPTH] && ref_t[a % DEPTH] == a / DEPTH;
   endfunction
   function automatic void ref_put(int a);
      ref_v[a % DEPTH] = 1'b1;
      ref_t[a % DEPTH] = a / DEPTH;
   endfunction

   task automatic chk(string tg, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      forever begin
         #1;
         if (cpu_done || n > 64) break;
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_read(int a, string tg);
      int n, c0, got;
      bit hit;
      hit = ref_hit(a);
      c0  = l1_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ADDR_W'(a);
      wait_done(n);
      got = int'(cpu_rdata);
      chk(tg, "load latency", n, hit ? 0 : L1_LAT + 1);
      chk(tg, "load data", got, int'(mem[a]));
      @(negedge clk);
      cpu_req = 1'b0;
      chk(tg, "L1 requests for load", l1_cnt - c0, hit ? 0 : 1);
      if (!hit) ref_put(a);
   endtask

   task automatic do_write(int a, int d, string tg);
      int n, c0;
      c0 = l1_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ADDR_W'(a); cpu_wdata = DATA_W'(d);
      wait_done(n);
      chk(tg, "store latency", n, L1_LAT + 1);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      chk(tg, "L1 holds stored word", int'(mem[a]), d & 16'hFFFF);
      chk(tg, "L1 requests for store", l1_cnt - c0, 1);
   endtask

   task automatic do_pf(int a, string tg);
      int c0, dn;
      bit hit;
      hit = ref_hit(a);
      c0  = l1_cnt;
      dn  = 0;
      @(negedge clk);
      pf_valid = 1'b1; pf_addr = ADDR_W'(a);
      @(negedge clk);
      pf_valid = 1'b0;
      repeat (L1_LAT + 2) begin
         #1; if (cpu_done) dn++;
         @(negedge clk);
      end
      chk(tg, "L1 requests for prefetch", l1_cnt - c0, hit ? 0 : 1);
      chk(tg, "cpu_done during prefetch", dn, 0);
      if (!hit) ref_put(a);
   endtask

   // load of x with a prefetch of y in cycle 'at' of the load
   task automatic read_with_pf(int x, int y, int at, string tg);
      int n, c0;
      bit hit;
      hit = ref_hit(x);
      c0  = l1_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ADDR_W'(x); pf_addr = ADDR_W'(y);
      n = 0;
      forever begin
         pf_valid = (n == at);
         #1;
         if (cpu_done || n > 64) break;
         @(negedge clk);
         n++;
      end
      chk(tg, "load latency with prefetch", n, hit ? 0 : L1_LAT + 1);
      chk(tg, "load data with prefetch", int'(cpu_rdata), int'(mem[x]));
      @(negedge clk);
      cpu_req = 1'b0; pf_valid = 1'b0;
      chk(tg, "L1 requests, prefetch dropped", l1_cnt - c0, hit ? 0 : 1);
      if (!hit) ref_put(x);
   endtask

   // prefetch p (a miss), then a load of r in the next cycle
   task automatic pf_then_read(int p, int r, string tg);
      int n, c0, exp_n, exp_c;
      bit hit_r;
      c0 = l1_cnt;
      @(negedge clk);
      pf_valid = 1'b1; pf_addr = ADDR_W'(p);
      @(negedge clk);
      pf_valid = 1'b0;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ADDR_W'(r);
      ref_put(p);
      hit_r = ref_hit(r);
      if (r == p) begin exp_n = L1_LAT; exp_c = 1; end
      else if (hit_r) begin exp_n = L1_LAT + 1; exp_c = 1; end
      else begin exp_n = 2 * L1_LAT + 2; exp_c = 2; end
      wait_done(n);
      chk(tg, "load behind prefetch latency", n, exp_n);
      chk(tg, "load behind prefetch data", int'(cpu_rdata), int'(mem[r]));
      @(negedge clk);
      cpu_req = 1'b0;
      chk("R12", "L1 requests behind prefetch", l1_cnt - c0, exp_c);
      ref_put(r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin ref_v[i] = 1'b0; ref_t[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: quiet outputs and empty buffer after reset
      chk("R1", "l1_req after reset", int'(l1_req), 0);
      chk("R1", "cpu_done after reset", int'(cpu_done), 0);
      do_read(5, "R1");
      // R3: sweep every address
      for (int a = 0; a < NADDR; a++) do_read(a, "R3");
      // R2: second load of each address hits
      for (int a = 0; a < NADDR; a += 3) begin
         do_read(a, "R3");
         do_read(a, "R2");
      end
      // R4: same index, other tag evicts
      for (int i = 0; i < DEPTH; i++) begin
         do_read(i, "R4");
         do_read(i + DEPTH * 5, "R4");
         do_read(i, "R4");
      end
      // R5 / R6: store-through, update on hit, no allocate on miss
      for (int a = 16; a < 32; a++) begin
         do_read(a, "R5");
         do_write(a, a * 7 + 1, "R5");
         do_read(a, "R5");
         do_write(a + 128, a * 11 + 3, "R6");
         do_read(a, "R6");
         do_read(a + 128, "R6");
      end
      // R7 / R8: prefetch fill and prefetch hit filter
      for (int a = 64; a < 80; a++) begin
         do_pf(a, "R7");
         do_read(a, "R7");
         do_pf(a, "R8");
      end
      // R9: prefetch during an outstanding miss is dropped
      for (int i = 0; i < 4; i++) begin
         read_with_pf(200 + i, 160 + ((i + 4) % 8), 1, "R9");
         do_read(160 + ((i + 4) % 8), "R9");
      end
      // R10: same-cycle processor request wins
      for (int i = 0; i < 4; i++) begin
         read_with_pf(200 + i, 168 + ((i + 4) % 8), 0, "R10");
         do_read(168 + ((i + 4) % 8), "R10");
         read_with_pf(136 + i, 152 + ((i + 4) % 8), 0, "R10");
         do_read(152 + ((i + 4) % 8), "R10");
      end
      // R11: load to the in-flight prefetch address, and to other addresses
      for (int i = 0; i < 4; i++) begin
         pf_then_read(176 + i, 176 + i, "R11");
         pf_then_read(184 + ((i + 4) % 8), 208 + i, "R11");
         pf_then_read(232 + ((i + 4) % 8), 176 + i, "R11");
      end
      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule